// File: doc/BRIEF.md
# Bidirectional Latched/Registered Bus Transceiver

This block passes data between two parallel buses, an A side and a B side, 18 bits wide by default and never inverted. Each direction owns one storage stage with three modes: a pass-through mode that forwards the incoming bus in the same cycle, a hold mode that keeps the last stored word, and a capture mode that stores the incoming bus when that direction's capture strobe rises. Each direction also has an output enable that decides whether the block drives the far bus. The A-to-B enable is active high. The B-to-A enable is active low.

The buses are modelled as separate input, output and output-enable signals. A chip-level pad ring or tristate stage turns an enable that is low into high impedance. The block works in the `clk` domain. Each direction's capture strobe is sampled on `clk`, and a capture takes place in the first cycle in which the strobe is seen high after being seen low. The data buses carry no valid/ready handshake. A transceiver forwards whatever is on its input and cannot apply back-pressure to it, so every data and control pin is plain.

An active-low asynchronous reset stands in for power-up. While reset is asserted, both output enables are forced off and both stored words are cleared. If both directions are enabled at once, the block raises a contention flag.

Top module: `xcv_bus_transceiver`

## Requirements
- R1: When a direction's pass enable (`ab_pass`, `ba_pass`) is 1, that direction's output equals its input in the same cycle, bit for bit and not inverted.
- R2: When the pass enable is 0 and the capture strobe does not rise, the output keeps its value. This holds whether the strobe is held at 0 or held at 1, and a falling strobe causes no capture.
- R3: When the pass enable is 0 and the strobe is sampled at 1 in a cycle after it was sampled at 0, the input from that cycle is stored and appears on the output from the next cycle onward.
- R4: When the pass enable goes from 1 to 0, the output holds the input value from the last cycle in which the pass enable was 1.
- R5: `b_oe` is 1 exactly when `ab_drive` is 1 (active high) and reset is released.
- R6: `a_oe` is 1 exactly when `ba_drive_n` is 0 (active low) and reset is released.
- R7: While `rst_n` is 0, both output enables are 0 at once (asynchronously) and both stored words are zero. After release, a strobe that is already at 1 does not capture until it has been seen at 0.
- R8: `contention` is 1 exactly when `a_oe` and `b_oe` are both 1.
- R9: The two directions are independent: no control or data input of one direction changes the output of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples strobes and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset (power-up stand-in) |
| a_in | input | 18 | Data received from the A bus |
| a_out | output | 18 | Data to drive onto the A bus |
| a_oe | output | 1 | 1 = drive A bus, 0 = release (high impedance) |
| b_in | input | 18 | Data received from the B bus |
| b_out | output | 18 | Data to drive onto the B bus |
| b_oe | output | 1 | 1 = drive B bus, 0 = release (high impedance) |
| ab_pass | input | 1 | A-to-B pass enable; 1 = pass-through mode |
| ab_strobe | input | 1 | A-to-B capture strobe; a rise captures |
| ab_drive | input | 1 | A-to-B output enable, active high |
| ba_pass | input | 1 | B-to-A pass enable; 1 = pass-through mode |
| ba_strobe | input | 1 | B-to-A capture strobe; a rise captures |
| ba_drive_n | input | 1 | B-to-A output enable, active low |
| contention | output | 1 | Both buses driven at once |

## Verification
On every cycle the assertions check pass-through equality, output stability in hold mode with no strobe rise, the value after a capture, the polarity of each enable, the contention flag, and the cleared state after reset. Only the bench scenarios show the following: that the value held after the pass enable falls is the last value passed, that a strobe still high when reset is released does not capture, and that activity in one direction leaves the other direction's output unchanged. The bench compares every output against its own reference model under random mode, strobe and enable traffic.

// File: rtl/xcv_pkg.sv
package xcv_pkg;
  localparam int unsigned XCV_WIDTH = 18;

  typedef enum logic [1:0] {
    XCV_PASS    = 2'd0,
    XCV_HOLD    = 2'd1,
    XCV_CAPTURE = 2'd2
  } xcv_mode_e;
endpackage

// File: rtl/xcv_rise_detect.sv
module xcv_rise_detect #(
  parameter bit IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  // Resetting to 1 means a strobe already high at release is not a rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= IDLE_LEVEL;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/xcv_store.sv
module xcv_store
  import xcv_pkg::*;
#(
  parameter int unsigned WIDTH = XCV_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pass,
  input  logic             rise,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output xcv_mode_e        mode
);
  always_comb begin
    if (pass)      mode = XCV_PASS;
    else if (rise) mode = XCV_CAPTURE;
    else           mode = XCV_HOLD;
  end

  // Tracking the input while passing leaves the last passed word stored when pass falls.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (mode != XCV_HOLD) q <= d;
  end
endmodule

// File: rtl/xcv_lane.sv
module xcv_lane
  import xcv_pkg::*;
#(
  parameter int unsigned WIDTH         = XCV_WIDTH,
  parameter bit          OE_ACTIVE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pass,
  input  logic             strobe,
  input  logic             drive_req,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             oe
);
  logic             rise;
  logic [WIDTH-1:0] stored;
  xcv_mode_e        mode;
  logic             drive_act;

  xcv_rise_detect #(.IDLE_LEVEL(1'b1)) u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .level (strobe),
    .rise  (rise)
  );

  xcv_store #(.WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .pass  (pass),
    .rise  (rise),
    .d     (d),
    .q     (stored),
    .mode  (mode)
  );

  // The pass path bypasses the register, so pass-through adds no cycle of delay.
  assign q = (mode == XCV_PASS) ? d : stored;

  generate
    if (OE_ACTIVE_LOW) begin : g_oe_low
      assign drive_act = ~drive_req;
    end else begin : g_oe_high
      assign drive_act = drive_req;
    end
  endgenerate

  assign oe = rst_n & drive_act;
endmodule

// File: rtl/xcv_bus_transceiver.sv
module xcv_bus_transceiver
  import xcv_pkg::*;
#(
  parameter int unsigned WIDTH = XCV_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             ab_pass,
  input  logic             ab_strobe,
  input  logic             ab_drive,
  input  logic             ba_pass,
  input  logic             ba_strobe,
  input  logic             ba_drive_n,
  output logic             contention
);
  localparam int unsigned NDIR = 2;  // index 0: A to B, index 1: B to A

  logic [NDIR-1:0][WIDTH-1:0] src;
  logic [NDIR-1:0][WIDTH-1:0] dst;
  logic [NDIR-1:0]            pass_v;
  logic [NDIR-1:0]            strobe_v;
  logic [NDIR-1:0]            drive_v;
  logic [NDIR-1:0]            oe_v;

  assign src      = {b_in, a_in};
  assign pass_v   = {ba_pass, ab_pass};
  assign strobe_v = {ba_strobe, ab_strobe};
  assign drive_v  = {ba_drive_n, ab_drive};

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    xcv_lane #(
      .WIDTH         (WIDTH),
      .OE_ACTIVE_LOW (g == 1)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .pass      (pass_v[g]),
      .strobe    (strobe_v[g]),
      .drive_req (drive_v[g]),
      .d         (src[g]),
      .q         (dst[g]),
      .oe        (oe_v[g])
    );
  end

  assign b_out      = dst[0];
  assign b_oe       = oe_v[0];
  assign a_out      = dst[1];
  assign a_oe       = oe_v[1];
  assign contention = &oe_v;
endmodule

// File: rtl/xcv_bus_transceiver_chk.sv
module xcv_bus_transceiver_chk #(
  parameter int unsigned WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic             ab_pass,
  input logic             ab_strobe,
  input logic             ab_drive,
  input logic             ba_pass,
  input logic             ba_strobe,
  input logic             ba_drive_n,
  input logic             contention
);
  // R1
  ab_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_pass |-> b_out == a_in);
  // R1
  ba_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba_pass |-> a_out == b_in);
  // R2
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_pass && !$past(ab_pass) && !($past(ab_strobe) && !$past(ab_strobe, 2)))
      |-> $stable(b_out));
  // R2
  ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_pass && !$past(ba_pass) && !($past(ba_strobe) && !$past(ba_strobe, 2)))
      |-> $stable(a_out));
  // R3
  ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_pass && ab_strobe && !$past(ab_strobe) && $past(rst_n))
      |=> (ab_pass || b_out == $past(a_in)));
  // R3
  ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_pass && ba_strobe && !$past(ba_strobe) && $past(rst_n))
      |=> (ba_pass || a_out == $past(b_in)));
  // R5
  ab_oe_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_oe == ab_drive);
  // R6
  ba_oe_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe == !ba_drive_n);
  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !ab_pass) |-> b_out == '0);
  // R8
  contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    contention == (a_oe && b_oe));

  // R7
  always_comb begin
    if (!rst_n) begin
      reset_release_chk: assert (!a_oe && !b_oe && !contention);
    end
  end
endmodule

bind xcv_bus_transceiver xcv_bus_transceiver_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .a_in       (a_in),
  .a_out      (a_out),
  .a_oe       (a_oe),
  .b_in       (b_in),
  .b_out      (b_out),
  .b_oe       (b_oe),
  .ab_pass    (ab_pass),
  .ab_strobe  (ab_strobe),
  .ab_drive   (ab_drive),
  .ba_pass    (ba_pass),
  .ba_strobe  (ba_strobe),
  .ba_drive_n (ba_drive_n),
  .contention (contention)
);

// File: tb/test_xcv_bus_transceiver.sv
module test_xcv_bus_transceiver;
  localparam int unsigned W          = 18;
  localparam int unsigned CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe, contention;
  logic         ab_pass, ab_strobe, ab_drive;
  logic         ba_pass, ba_strobe, ba_drive_n;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  logic [W-1:0] m_ab, m_ba;
  logic         m_ab_prev, m_ba_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcv_bus_transceiver #(.WIDTH(W)) i_xcv_bus_transceiver (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_drive(ab_drive),
    .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n),
    .contention(contention)
  );

  function automatic logic [W-1:0] exp_out(logic pass, logic [W-1:0] din, logic [W-1:0] st);
    return pass ? din : st;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ab = '0; m_ba = '0; m_ab_prev = 1'b1; m_ba_prev = 1'b1;
  endtask

  // Check all outputs before the edge, then advance the model across it.
  task automatic cycle();
    logic eb_oe, ea_oe;
    #(CLK_PERIOD/4);
    eb_oe = rst_n & ab_drive;
    ea_oe = rst_n & ~ba_drive_n;
    chk(ab_pass ? "R1 b_out" : "R2/R3 b_out", b_out, exp_out(ab_pass, a_in, m_ab));
    chk(ba_pass ? "R1 a_out" : "R2/R3 a_out", a_out, exp_out(ba_pass, b_in, m_ba));
    chk("R5 b_oe", W'(b_oe), W'(eb_oe));
    chk("R6 a_oe", W'(a_oe), W'(ea_oe));
    chk("R8 contention", W'(contention), W'(ea_oe & eb_oe));
    @(posedge clk);
    if (rst_n) begin
      if (ab_pass || (ab_strobe && !m_ab_prev)) m_ab = a_in;
      if (ba_pass || (ba_strobe && !m_ba_prev)) m_ba = b_in;
      m_ab_prev = ab_strobe;
      m_ba_prev = ba_strobe;
    end
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    a_in = '0; b_in = '0;
    ab_pass = 1'b0; ab_strobe = 1'b0; ab_drive = 1'b1;
    ba_pass = 1'b0; ba_strobe = 1'b0; ba_drive_n = 1'b0;
    model_reset();
    void'($urandom(32'd20240611));
    @(negedge clk);
    #1;
    // r7_ reset state: enables forced off although both requested
    chk("R7 oe off in reset", W'({a_oe, b_oe, contention}), '0);
    chk("R7 b_out zero", b_out, '0);
    cycle();
    rst_n = 1'b1;
    cycle();

    // R1 transparent both ways
    ab_pass = 1'b1; ba_pass = 1'b1;
    a_in = 18'h2A5C3; b_in = 18'h15A3C;
    cycle();
    chk("R1 b_out follows a_in", b_out, 18'h2A5C3);
    a_in = 18'h3FFFF;
    #1 chk("R1 same cycle", b_out, 18'h3FFFF);
    cycle();

    // R4 pass falls: holds last passed value
    ab_pass = 1'b0; a_in = 18'h00123;
    cycle();
    chk("R4 held after pass fall", b_out, 18'h3FFFF);

    // R2 hold with strobe low, then strobe high (rise captures once), then high static
    a_in = 18'h11111; cycle();
    chk("R2 strobe low hold", b_out, 18'h3FFFF);
    ab_strobe = 1'b1; a_in = 18'h22222; cycle();
    chk("R3 capture on rise", b_out, 18'h22222);
    a_in = 18'h33333; cycle(); cycle();
    chk("R2 strobe high hold", b_out, 18'h22222);
    ab_strobe = 1'b0; a_in = 18'h04444; cycle();
    chk("R2 falling edge no capture", b_out, 18'h22222);

    // R9 B side activity leaves b_out alone
    ba_pass = 1'b0; ba_strobe = 1'b1; b_in = 18'h0ABCD; cycle();
    chk("R9 b_out unaffected", b_out, 18'h22222);
    chk("R3 a_out capture", a_out, 18'h0ABCD);

    // R5/R6/R8 polarity and contention
    ab_drive = 1'b0; ba_drive_n = 1'b1; #1;
    chk("R5 b_oe low", W'(b_oe), '0);
    chk("R6 a_oe low", W'(a_oe), '0);
    cycle();
    ab_drive = 1'b1; ba_drive_n = 1'b0; #1;
    chk("R8 contention", W'(contention), W'(1));
    cycle();

    // R7 reset mid-run with strobe held high through release
    ab_strobe = 1'b1; ab_pass = 1'b0;
    rst_n = 1'b0; #1;
    chk("R7 async oe off", W'({a_oe, b_oe}), '0);
    model_reset();
    cycle();
    rst_n = 1'b1; a_in = 18'h1234F;
    cycle();
    cycle();
    chk("R7 no capture of held strobe", b_out, '0);
    ab_strobe = 1'b0; cycle();
    ab_strobe = 1'b1; cycle();
    chk("R7 capture after low seen", b_out, 18'h1234F);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      a_in       = W'($urandom);
      b_in       = W'($urandom);
      ab_pass    = ($urandom % 4) == 0;
      ba_pass    = ($urandom % 4) == 0;
      ab_strobe  = $urandom % 2;
      ba_strobe  = $urandom % 2;
      ab_drive   = $urandom % 2;
      ba_drive_n = $urandom % 2;
      cycle();
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule